// File: doc/BRIEF.md
# Level-1 Trigger Gate with Busy and Fill-Level Throttling

This block sits between an upstream level-1 trigger source and a set of front-end digitizers. Each incoming trigger pulse comes with an event number and a trigger type. The block decides whether the trigger may be forwarded. A trigger is forwarded only when no digitizer reports busy, the downstream event FIFO is below a programmable almost-full threshold, and the local trigger queue has room. Each forwarded trigger goes out to the digitizers as a single-cycle pulse.

Every forwarded trigger also stores its event number and type as one entry in a trigger queue. While that queue holds anything, a level-sensitive interrupt tells the host that event data is ready to read. The host drains the queue through a first-word-fall-through read port. A trigger that is refused is not forwarded and is not stored. It only advances a lost-trigger counter, which software can read.

Top module: `trig_gate`

## Requirements
- R1: After reset, feTrig is 0, hostIrq is 0 and lostCount is 0.
- R2: A trigger sampled high on upTrig at a clock edge and accepted produces feTrig high for exactly the one cycle after that edge.
- R3: While any bit of feBusy is 1, a trigger is not forwarded.
- R4: While evtLevel is greater than or equal to afThresh, a trigger is not forwarded; at evtLevel equal to afThresh minus one it is forwarded.
- R5: Each refused trigger raises lostCount by exactly one in the cycle after it is sampled; accepted triggers leave it unchanged.
- R6: Each accepted trigger stores one entry, with the type in hostData[23:16] and the event number in hostData[15:0]; entries are read back in arrival order.
- R7: hostIrq is 1 exactly while the trigger queue is non-empty, and it falls after the host pops the last entry.
- R8: When the queue already holds DEPTH entries, a new trigger is refused, is not forwarded, and is counted as lost.
- R9: A hostPop while the queue is empty has no effect: hostIrq stays 0 and the next stored entry reads back correctly.
- R10: A trigger accepted in the same cycle as a pop keeps the queue order and leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| upTrig | input | 1 | Upstream level-1 trigger, one cycle per trigger |
| upEvtNum | input | 16 | Event number that comes with the trigger |
| upTrigType | input | 8 | Trigger type that comes with the trigger |
| feBusy | input | NUM_FE | Busy flag from each digitizer |
| feTrig | output | 1 | Trigger pulse forwarded to the digitizers |
| evtLevel | input | LVL_W | Fill level of the downstream event FIFO |
| afThresh | input | LVL_W | Almost-full threshold |
| lostCount | output | LOST_W | Number of refused triggers |
| hostIrq | output | 1 | Event-ready interrupt, high while the queue is non-empty |
| hostPop | input | 1 | Host pops the front entry of the queue |
| hostData | output | 24 | Front entry of the queue: {type, event number} |

## Verification
On every cycle, the assertions check the following:
- a forwarded pulse always follows a sampled trigger that was not blocked by busy or by the threshold;
- a refused trigger adds exactly one to the lost counter;
- the queue never takes a push while full;
- a pop on an empty queue changes nothing.

Ordering of stored entries, their field contents, and the interrupt falling after the last pop can only be shown by the bench's scenarios. The bench uses a queue of expected entries to check these. The same applies to the exact boundary at the threshold and to the interplay of a push and a pop in the same cycle.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int EVT_W  = 16;
  localparam int TYPE_W = 8;
  localparam int ENTRY_W = EVT_W + TYPE_W;

  typedef struct packed {
    logic [TYPE_W-1:0] trigType;
    logic [EVT_W-1:0]  evtNum;
  } tgEntry_t;

  typedef struct packed {
    logic accept;
    logic lose;
    logic pop;
  } tgStrobe_t;
endpackage

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
#(
  parameter int NUM_FE = 4,
  parameter int LVL_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upTrig,
  input  logic [NUM_FE-1:0] feBusy,
  input  logic [LVL_W-1:0]  evtLevel,
  input  logic [LVL_W-1:0]  afThresh,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              hostPop,
  output tgStrobe_t         strobe,
  output logic              feTrig
);
  logic anyBusy;
  logic throttled;
  logic blocked;

  assign anyBusy   = |feBusy;
  assign throttled = (evtLevel >= afThresh);
  assign blocked   = anyBusy | throttled | fifoFull;

  always_comb begin
    strobe.accept = upTrig & ~blocked;
    strobe.lose   = upTrig & blocked;
    strobe.pop    = hostPop & ~fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) feTrig <= 1'b0;
    else       feTrig <= strobe.accept;
  end

  // R2
  fe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    feTrig |-> $past(upTrig));
  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    feTrig |-> ($past(feBusy) == '0));
  // R4
  thresh_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    feTrig |-> ($past(evtLevel) < $past(afThresh)));
endmodule

// File: rtl/tg_datapath.sv
module tg_datapath
  import tg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LOST_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgStrobe_t         strobe,
  input  tgEntry_t          inEntry,
  output tgEntry_t          outEntry,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [LOST_W-1:0] lostCount
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  tgEntry_t         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;

  assign fifoFull  = (count == FULL_CNT);
  assign fifoEmpty = (count == '0);
  assign outEntry  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.accept) mem[wrPtr] <= inEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.accept) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)    rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strobe.accept, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            lostCount <= '0;
    else if (strobe.lose) lostCount <= lostCount + 1'b1;
  end

  // R5
  lost_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lose |=> (lostCount == $past(lostCount) + 1'b1));
  // R5
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lose |=> $stable(lostCount));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |-> (count < FULL_CNT) || strobe.pop);
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && !strobe.accept) |=> fifoEmpty);
  // R10
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && strobe.pop) |=> $stable(count));
endmodule

// File: rtl/trig_gate.sv
module trig_gate
  import tg_pkg::*;
#(
  parameter int NUM_FE = 4,
  parameter int LVL_W  = 10,
  parameter int DEPTH  = 8,
  parameter int LOST_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upTrig,
  input  logic [15:0]       upEvtNum,
  input  logic [7:0]        upTrigType,
  input  logic [NUM_FE-1:0] feBusy,
  output logic              feTrig,
  input  logic [LVL_W-1:0]  evtLevel,
  input  logic [LVL_W-1:0]  afThresh,
  output logic [LOST_W-1:0] lostCount,
  output logic              hostIrq,
  input  logic              hostPop,
  output logic [23:0]       hostData
);
  tgStrobe_t strobe;
  tgEntry_t  inEntry;
  tgEntry_t  outEntry;
  logic      fifoFull;
  logic      fifoEmpty;

  assign inEntry.trigType = upTrigType;
  assign inEntry.evtNum   = upEvtNum;
  assign hostData         = outEntry;
  assign hostIrq          = ~fifoEmpty;

  tg_ctrl #(.NUM_FE(NUM_FE), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .upTrig(upTrig), .feBusy(feBusy),
    .evtLevel(evtLevel), .afThresh(afThresh), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .hostPop(hostPop), .strobe(strobe), .feTrig(feTrig)
  );

  tg_datapath #(.DEPTH(DEPTH), .LOST_W(LOST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inEntry(inEntry),
    .outEntry(outEntry), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .lostCount(lostCount)
  );

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hostIrq) && !hostIrq) |-> $past(hostPop));
endmodule

// File: tb/test_trig_gate.sv
module test_trig_gate;
  localparam int DEPTH = 8;
  logic clk = 0;
  logic rstN = 0;
  logic upTrig = 0;
  logic [15:0] upEvtNum = 0;
  logic [7:0] upTrigType = 0;
  logic [3:0] feBusy = 0;
  logic feTrig;
  logic [9:0] evtLevel = 0;
  logic [9:0] afThresh = 10'd16;
  logic [15:0] lostCount;
  logic hostIrq;
  logic hostPop = 0;
  logic [23:0] hostData;

  int checks = 0;
  int errors = 0;
  int expLost = 0;
  bit done = 0;
  logic [23:0] expQ[$];

  always #10 clk = ~clk;

  trig_gate i_trig_gate (
    .clk(clk), .rstN(rstN), .upTrig(upTrig), .upEvtNum(upEvtNum),
    .upTrigType(upTrigType), .feBusy(feBusy), .feTrig(feTrig),
    .evtLevel(evtLevel), .afThresh(afThresh), .lostCount(lostCount),
    .hostIrq(hostIrq), .hostPop(hostPop), .hostData(hostData)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: one trigger, expected entry queued when acceptance is expected
  task automatic sendTrig(logic [15:0] num, logic [7:0] typ, bit expAcc, string req);
    @(negedge clk);
    upTrig = 1; upEvtNum = num; upTrigType = typ;
    if (expAcc) expQ.push_back({typ, num}); else expLost++;
    @(negedge clk);
    upTrig = 0;
    check(req, feTrig, expAcc);
    check(req, lostCount, expLost[15:0]);
    @(negedge clk);
    check({req, " R2 pulse"}, feTrig, 0);
  endtask

  // monitor: pops the front and compares against the scoreboard
  task automatic popCheck(string req);
    logic [23:0] exp;
    @(negedge clk);
    exp = expQ.pop_front();
    check({req, " irq"}, hostIrq, 1);
    check(req, hostData, exp);
    hostPop = 1;
    @(negedge clk);
    hostPop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", feTrig, 0);
    check("R1", hostIrq, 0);
    check("R1", lostCount, 0);
    rstN = 1;

    // R2 R6 plain accepts
    sendTrig(16'h0101, 8'h11, 1, "R2");
    sendTrig(16'h0202, 8'h22, 1, "R6");
    check("R7 irq set", hostIrq, 1);

    // R3 busy blocks from any digitizer
    feBusy = 4'b0100;
    sendTrig(16'h0303, 8'h33, 0, "R3");
    feBusy = 4'b0001;
    sendTrig(16'h0304, 8'h34, 0, "R3");
    feBusy = 0;

    // R4 threshold boundary
    evtLevel = 10'd16;
    sendTrig(16'h0404, 8'h44, 0, "R4 at threshold");
    evtLevel = 10'd15;
    sendTrig(16'h0505, 8'h55, 1, "R4 below threshold");
    evtLevel = 0;

    // R6 R7 drain in order, irq falls after last
    popCheck("R6"); popCheck("R6"); popCheck("R6");
    check("R7 irq clear", hostIrq, 0);

    // R9 pop on empty
    @(negedge clk); hostPop = 1;
    @(negedge clk); hostPop = 0;
    check("R9 irq", hostIrq, 0);
    check("R9 lost", lostCount, expLost[15:0]);
    sendTrig(16'h0606, 8'h66, 1, "R9");
    popCheck("R9");

    // R8 fill to DEPTH, then one is refused
    for (int i = 0; i < DEPTH; i++) sendTrig(16'h1000 + 16'(i), 8'h70 + 8'(i), 1, "R8 fill");
    sendTrig(16'h1FFF, 8'h7F, 0, "R8 full");
    for (int i = 0; i < DEPTH; i++) popCheck("R8");
    check("R8 drained", hostIrq, 0);

    // R10 push and pop in the same cycle
    sendTrig(16'h2001, 8'hA1, 1, "R10");
    @(negedge clk);
    check("R10 front", hostData, expQ[0]);
    upTrig = 1; upEvtNum = 16'h2002; upTrigType = 8'hA2; hostPop = 1;
    void'(expQ.pop_front());
    expQ.push_back({8'hA2, 16'h2002});
    @(negedge clk);
    upTrig = 0; hostPop = 0;
    check("R10 fwd", feTrig, 1);
    check("R10 irq", hostIrq, 1);
    popCheck("R10");
    check("R10 empty", hostIrq, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule